// File: doc/BRIEF.md
# Dual-Bank LED Blink and Dim Controller

This block drives sixteen active-low LED switch outputs from two shared blink/dim generators. Each generator has its own 8-bit frequency prescaler and its own 8-bit duty value. A 2-bit selector per output picks one of four sources for that output: forced off, forced on, generator 0 or generator 1. Because the generators are shared, any number of LEDs can blink in step at one rate and brightness while the rest follow the second generator or sit at a fixed level.

Software reaches the settings through a byte-wide register port. An address is loaded once, and each later write or read moves the pointer forward by one, so a single transfer can fill a run of registers. Two read-only locations return the synchronized state of the sixteen LED pins. A divider built from the system clock produces a base step at 256 times 160 Hz. Each generator runs 256 phase steps per blink period, and each phase step lasts (PSC+1) base steps. This gives periods from 1/160 s (PSC=0) to 1.6 s (PSC=255).

Top module: `led_blink_core`

## Requirements
- R1: After reset every output `led_o` bit is 1 (off) and every writable register reads 0.
- R2: Writable registers sit at address 0x02 prescaler 0, 0x03 duty 0, 0x04 prescaler 1, 0x05 duty 1 and 0x06..0x09 selectors, and each reads back the last byte written to it.
- R3: Each write or read access moves the pointer to the next address, and it wraps from 0x09 to 0x00. Loading an address above 0x09 sets the pointer to 0x00.
- R4: Address 0x00 returns pin bits 7:0 and address 0x01 returns pin bits 15:8, taken through a two-flop synchronizer. Writes to these two addresses change no register but still advance the pointer.
- R5: The selector for output k is bits [2*(k%4)+1 : 2*(k%4)] of register 0x06+k/4. Code 00 drives 1 (off), 01 drives 0 (on), 10 follows generator 0 and 11 follows generator 1. `led_o` takes a new selector value on the clock edge after the write edge.
- R6: A generator moves its phase once every (PSC+1)*BASE_DIV clocks, and one full period is 256 phase steps.
- R7: A mapped output is low while the phase count is below the duty value. Over one period it is low for duty*(PSC+1)*BASE_DIV clocks and falls once. Duty 0 never drives it low.
- R8: The two generators run independently: changing one generator's settings leaves the waveform of outputs mapped to the other unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_load_i | input | 1 | Load `addr_i` into the register pointer |
| addr_i | input | 4 | Start address of a transfer |
| wr_en_i | input | 1 | Write `wdata_i` at the pointer, then advance the pointer |
| wdata_i | input | 8 | Write data |
| rd_en_i | input | 1 | Read access done; advance the pointer |
| rdata_o | output | 8 | Register at the pointer (combinational) |
| pin_i | input | 16 | Sensed LED pin levels |
| led_o | output | 16 | LED switch drive, 0 = sinking (on) |

## Verification
A register write is visible on `rdata_o` half a cycle after its write edge. An output whose selector changes moves one edge later, so the bench samples at the next falling edge. Pin changes need two edges before they can be read. Generator results are not sampled at single points. The bench first waits 2*(PSC+1)+4 cycles so the prescaler and output register settle after a change. It then counts low cycles and falling edges over a window of exactly one period, 256*(PSC+1) clocks. These counts do not depend on where the window starts, so the arithmetic expectation holds whatever the phase alignment.

// File: rtl/led_blink_pkg.sv
package led_blink_pkg;
  localparam int unsigned NUM_LED  = 16;
  localparam int unsigned NUM_GEN  = 2;
  localparam int unsigned CFG_REGS = 8;

  typedef enum logic [1:0] {
    SEL_OFF = 2'b00,
    SEL_ON  = 2'b01,
    SEL_G0  = 2'b10,
    SEL_G1  = 2'b11
  } led_sel_e;

  localparam logic [3:0] ADDR_PIN_LO = 4'd0;
  localparam logic [3:0] ADDR_PIN_HI = 4'd1;
  localparam logic [3:0] ADDR_CFG0   = 4'd2;
  localparam logic [3:0] ADDR_LAST   = 4'd9;
endpackage

// File: rtl/led_step_gen.sv
module led_step_gen #(
  parameter int unsigned BASE_DIV = 1221
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic step_o
);
  generate
    if (BASE_DIV <= 1) begin : g_every
      assign step_o = 1'b1;
    end else begin : g_div
      localparam int unsigned CW = $clog2(BASE_DIV);
      localparam logic [CW-1:0] LAST = CW'(BASE_DIV - 1);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)            cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
      end
      assign step_o = (cnt_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/led_pwm_gen.sv
module led_pwm_gen (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       step_i,
  input  logic [7:0] psc_i,
  input  logic [7:0] duty_i,
  output logic       on_o
);
  logic [7:0] pre_q;
  logic [7:0] phase_q;

  // >= lets a lowered prescaler take effect at once
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q   <= '0;
      phase_q <= '0;
    end else if (step_i) begin
      if (pre_q >= psc_i) begin
        pre_q   <= '0;
        phase_q <= phase_q + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  assign on_o = (phase_q < duty_i);

  p_phase_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(phase_q));
  p_phase_one_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> (phase_q == $past(phase_q)) || (phase_q == $past(phase_q) + 8'd1));
endmodule

// File: rtl/led_regfile.sv
module led_regfile
  import led_blink_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            addr_load_i,
  input  logic [3:0]                      addr_i,
  input  logic                            wr_en_i,
  input  logic [7:0]                      wdata_i,
  input  logic                            rd_en_i,
  input  logic [NUM_LED-1:0]              pin_i,
  output logic [7:0]                      rdata_o,
  output logic [NUM_GEN-1:0][7:0]         psc_o,
  output logic [NUM_GEN-1:0][7:0]         duty_o,
  output logic [NUM_LED-1:0][1:0]         sel_o
);
  logic [7:0]                         cfg_q [CFG_REGS];
  logic [3:0]                         ptr_q;
  logic [3:0]                         eff_addr;
  logic [3:0]                         next_addr;
  logic [2:0]                         eff_idx;
  logic [2:0]                         ptr_idx;
  logic                               cfg_hit;
  logic [SYNC_STAGES-1:0][NUM_LED-1:0] sync_q;
  logic [NUM_LED-1:0]                 pin_s;
  logic [CFG_REGS*8-1:0]              cfg_flat;

  assign eff_addr  = addr_load_i ? ((addr_i > ADDR_LAST) ? 4'd0 : addr_i) : ptr_q;
  assign next_addr = (eff_addr == ADDR_LAST) ? 4'd0 : eff_addr + 4'd1;
  // addresses 2..9 map onto 0..7 modulo 8
  assign eff_idx   = eff_addr[2:0] - 3'd2;
  assign ptr_idx   = ptr_q[2:0] - 3'd2;
  assign cfg_hit   = (eff_addr >= ADDR_CFG0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (wr_en_i || rd_en_i) begin
      ptr_q <= next_addr;
    end else if (addr_load_i) begin
      ptr_q <= eff_addr;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < CFG_REGS; i++) cfg_q[i] <= '0;
    end else if (wr_en_i && cfg_hit) begin
      cfg_q[eff_idx] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
  end
  assign pin_s = sync_q[SYNC_STAGES-1];

  always_comb begin
    case (ptr_q)
      ADDR_PIN_LO: rdata_o = pin_s[7:0];
      ADDR_PIN_HI: rdata_o = pin_s[15:8];
      default:     rdata_o = cfg_q[ptr_idx];
    endcase
  end

  genvar g, k, c;
  generate
    for (g = 0; g < NUM_GEN; g++) begin : g_gen_map
      assign psc_o[g]  = cfg_q[2*g];
      assign duty_o[g] = cfg_q[2*g+1];
    end
    for (k = 0; k < NUM_LED; k++) begin : g_sel_map
      assign sel_o[k] = cfg_q[4 + k/4][2*(k%4) +: 2];
    end
    for (c = 0; c < CFG_REGS; c++) begin : g_flat
      assign cfg_flat[8*c +: 8] = cfg_q[c];
    end
  endgenerate

  p_ptr_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_q <= ADDR_LAST);
  p_ptr_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !addr_load_i && ptr_q == ADDR_LAST) |=> (ptr_q == 4'd0));
  p_ro_ignored_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && eff_addr < ADDR_CFG0) |=> $stable(cfg_flat));
  p_idle_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(cfg_flat));
endmodule

// File: rtl/led_out_mux.sv
module led_out_mux
  import led_blink_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NUM_LED-1:0][1:0] sel_i,
  input  logic [NUM_GEN-1:0]      gen_on_i,
  output logic [NUM_LED-1:0]      led_o
);
  genvar k;
  generate
    for (k = 0; k < NUM_LED; k++) begin : g_led
      logic on_d;
      always_comb begin
        case (led_sel_e'(sel_i[k]))
          SEL_ON:  on_d = 1'b1;
          SEL_G0:  on_d = gen_on_i[0];
          SEL_G1:  on_d = gen_on_i[1];
          default: on_d = 1'b0;
        endcase
      end
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) led_o[k] <= 1'b1;
        else         led_o[k] <= ~on_d;
      end

      p_off_high_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_i[k] == SEL_OFF) |=> led_o[k]);
      p_on_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_i[k] == SEL_ON) |=> !led_o[k]);
    end
  endgenerate
endmodule

// File: rtl/led_blink_core.sv
module led_blink_core
  import led_blink_pkg::*;
#(
  parameter int unsigned BASE_DIV    = 1221,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        addr_load_i,
  input  logic [3:0]  addr_i,
  input  logic        wr_en_i,
  input  logic [7:0]  wdata_i,
  input  logic        rd_en_i,
  output logic [7:0]  rdata_o,
  input  logic [15:0] pin_i,
  output logic [15:0] led_o
);
  logic [NUM_GEN-1:0][7:0] psc;
  logic [NUM_GEN-1:0][7:0] duty;
  logic [NUM_LED-1:0][1:0] sel;
  logic [NUM_GEN-1:0]      gen_on;
  logic                    step;

  led_regfile #(.SYNC_STAGES(SYNC_STAGES)) u_regs (
    .clk_i, .rst_ni, .addr_load_i, .addr_i, .wr_en_i, .wdata_i, .rd_en_i,
    .pin_i, .rdata_o, .psc_o(psc), .duty_o(duty), .sel_o(sel)
  );

  led_step_gen #(.BASE_DIV(BASE_DIV)) u_step (
    .clk_i, .rst_ni, .step_o(step)
  );

  genvar g;
  generate
    for (g = 0; g < NUM_GEN; g++) begin : g_pwm
      led_pwm_gen u_pwm (
        .clk_i, .rst_ni, .step_i(step),
        .psc_i(psc[g]), .duty_i(duty[g]), .on_o(gen_on[g])
      );
    end
  endgenerate

  led_out_mux u_mux (
    .clk_i, .rst_ni, .sel_i(sel), .gen_on_i(gen_on), .led_o
  );

  generate
    for (g = 0; g < NUM_LED; g++) begin : g_chk
      p_duty_zero_dark_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((sel[g] == SEL_G0 && duty[0] == 8'd0) || (sel[g] == SEL_G1 && duty[1] == 8'd0))
        |=> led_o[g]);
    end
  endgenerate
endmodule

// File: tb/tb_led_blink_core.sv
module tb_led_blink_core;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        addr_load_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic        wr_en_i = 1'b0;
  logic [7:0]  wdata_i = '0;
  logic        rd_en_i = 1'b0;
  logic [7:0]  rdata_o;
  logic [15:0] pin_i = '0;
  logic [15:0] led_o;

  int vectors = 0;
  int miscompares = 0;

  always #10 clk = ~clk;

  led_blink_core #(.BASE_DIV(1)) dut (
    .clk_i(clk), .rst_ni, .addr_load_i, .addr_i, .wr_en_i, .wdata_i,
    .rd_en_i, .rdata_o, .pin_i, .led_o
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic reg_load(input logic [3:0] a);
    @(negedge clk); addr_load_i = 1'b1; addr_i = a;
    @(negedge clk); addr_load_i = 1'b0;
  endtask

  task automatic reg_wr(input logic [7:0] d);
    @(negedge clk); wr_en_i = 1'b1; wdata_i = d;
    @(negedge clk); wr_en_i = 1'b0;
  endtask

  task automatic reg_rd(input string tag, input logic [7:0] exp);
    @(negedge clk); chk(tag, rdata_o, exp); rd_en_i = 1'b1;
    @(negedge clk); rd_en_i = 1'b0;
  endtask

  task automatic set_sel(input logic [31:0] s);
    reg_load(4'd6);
    for (int i = 0; i < 4; i++) reg_wr(s[8*i +: 8]);
  endtask

  task automatic measure(input string tag, input int k, input int win,
                         input int exp_low, input int exp_falls);
    int low = 0;
    int falls = 0;
    logic prev;
    @(negedge clk); prev = led_o[k];
    for (int i = 0; i < win; i++) begin
      @(negedge clk);
      if (!led_o[k]) low++;
      if (prev && !led_o[k]) falls++;
      prev = led_o[k];
    end
    chk({tag, " low cycles"}, low, exp_low);
    chk({tag, " falling edges"}, falls, exp_falls);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [7:0] vals [8];
    logic [31:0] sel_word;
    logic [15:0] exp_led;
    int psc_list [3];
    int duty_list [6];
    psc_list  = '{0, 1, 3};
    duty_list = '{0, 1, 2, 127, 128, 255};

    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 led_o after reset", led_o, 16'hFFFF);
    reg_load(4'd2);
    for (int a = 2; a <= 9; a++) reg_rd("R1 register reset value", 8'h00);

    // R2 map and readback
    for (int i = 0; i < 8; i++) vals[i] = 8'(8'h11 * (i + 1) + 8'h03);
    reg_load(4'd2);
    for (int i = 0; i < 8; i++) reg_wr(vals[i]);
    reg_load(4'd2);
    for (int i = 0; i < 8; i++) reg_rd("R2 readback", vals[i]);

    // R3 wrap 9->0 and load beyond 9; R4 read-only writes ignored
    pin_i = 16'hC35A;
    reg_load(4'd9);
    reg_wr(8'hA5);
    reg_wr(8'h33);
    reg_wr(8'h44);
    reg_wr(8'h07);
    reg_load(4'd9);
    reg_rd("R3 sel reg 0x09", 8'hA5);
    reg_rd("R3 wrapped to 0x00 pin low", 8'h5A);
    reg_rd("R4 0x01 pin high", 8'hC3);
    reg_rd("R3 R4 0x02 after ignored writes", 8'h07);
    reg_rd("R4 0x03 unchanged", vals[1]);
    reg_load(4'd13);
    reg_rd("R3 load 13 lands on 0x00", 8'h5A);
    // R4 pin change visible after two edges
    @(negedge clk); pin_i = 16'h96E1;
    reg_load(4'd0);
    reg_rd("R4 new pin low", 8'hE1);
    reg_rd("R4 new pin high", 8'h96);

    // R5 exhaustive selector sweep, both generators at duty 0
    reg_load(4'd2);
    reg_wr(8'h00); reg_wr(8'h00); reg_wr(8'h00); reg_wr(8'h00);
    for (int k = 0; k < 16; k++) begin
      for (int c = 0; c < 4; c++) begin
        sel_word = 32'h5555_5555;
        sel_word[2*k +: 2] = 2'(c);
        set_sel(sel_word);
        @(negedge clk);
        exp_led = 16'h0000;
        exp_led[k] = (c == 1) ? 1'b0 : 1'b1;
        chk($sformatf("R5 out %0d code %0d", k, c), led_o, exp_led);
      end
    end

    // R6 R7 sweep on generator 0; generator 1 fixed for R8
    set_sel(32'h0000_001E);
    reg_load(4'd4);
    reg_wr(8'd2); reg_wr(8'd64);
    for (int p = 0; p < 3; p++) begin
      for (int d = 0; d < 6; d++) begin
        reg_load(4'd2);
        reg_wr(8'(psc_list[p])); reg_wr(8'(duty_list[d]));
        repeat (2 * (psc_list[p] + 1) + 4) @(negedge clk);
        measure($sformatf("R6 R7 psc %0d duty %0d", psc_list[p], duty_list[d]), 0,
                256 * (psc_list[p] + 1), duty_list[d] * (psc_list[p] + 1),
                (duty_list[d] != 0) ? 1 : 0);
      end
    end
    chk("R5 out2 on out3 off", {30'd0, led_o[3], led_o[2]}, 32'd2);
    measure("R8 generator 1 unaffected", 1, 768, 192, 1);
    reg_load(4'd2);
    reg_wr(8'd0); reg_wr(8'd0);
    repeat (6) @(negedge clk);
    measure("R8 generator 1 after gen 0 off", 1, 768, 192, 1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule